// File: doc/BRIEF.md
# Entropy Sample and Refill Sequencer

This block decides when an entropy accumulator is sampled and when a 64-bit random result taken from it is handed to software. After the enable rises it runs a startup phase of a configurable number of samples and loads the first result. It then runs refill phases between results. Sample strobes come from a clock divider. The accumulator itself sits outside the block and is presented on `pool_data`.

Results are offered as two 32-bit words with a ready flag. Software takes a result by pulsing `ack_rdy`. The block has one spare slot behind the output words. A result that finishes while the output is still unread waits in the spare slot, and it is handed over straight after the acknowledge. The handoff is flag based rather than valid/ready. Producer back-pressure is implicit: while both slots are full, no result is released and the refill counter holds at its limit.

A second status flag is set by an external shutdown-overflow event. Both raw flags are ORed into one interrupt. A per-flag mask gives the masked status view.

Top module: `entropy_refill_seq`

## Requirements
- R1: The startup phase ends with the first result loaded after T samples. T is the 16-bit startup field times 256, or 2^24 when the field is 0. With divider value d and enable raised before edge 0, the ready flag is set by clock edge (d+1)*T.
- R2: `sample_stb` pulses once every d+1 clocks while running, where d is the 4-bit divider field. It is 0 while the enable is low.
- R3: When the 8-bit minimum refill field is 0, a result is released once the maximum refill count has elapsed since the previous release. That count is the 16-bit field times 256, or 2^24 when the field is 0.
- R4: When the minimum refill field m is nonzero and m*64 does not exceed the maximum count, a result is released once m*64 samples have elapsed and the output slot is empty.
- R5: When the minimum refill count exceeds the maximum refill count, no refill result is ever released.
- R6: A released result puts `pool_data[31:0]` on `rnd_lo` and `pool_data[63:32]` on `rnd_hi` and sets `rdy_flag`. `ack_rdy` clears the flag. An `ack_rdy` while the flag is 0 changes nothing.
- R7: A result that finishes while the flag is set goes into the spare slot and leaves the output words unchanged. On the acknowledge the flag reads 0 for one cycle, then reads 1 with the spare value on the output words.
- R8: When the enable is low, `sample_stb` is 0 in the same cycle. After the next clock edge, `rdy_flag` is 0 and the spare slot is empty.
- R9: A configuration write (`cfg_we`) takes effect only while the enable is 0. A write made while the enable is 1 is ignored.
- R10: `busy` is 1 while the sequencer runs or `test_mode` is 1, and 0 otherwise.
- R11: `ovf_event` sets `ovf_flag` and `ack_ovf` clears it. When both arrive in one cycle, set wins. `irq_masked[0]` is `rdy_flag & irq_mask[0]` and `irq_masked[1]` is `ovf_flag & irq_mask[1]`. `irq` is the OR of the two raw flags.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the sequencer; low forces idle |
| test_mode | input | 1 | Test mode, keeps busy high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_startup | input | 16 | Startup sample count field |
| cfg_refill_max | input | 16 | Maximum refill sample count field |
| cfg_refill_min | input | 8 | Minimum refill sample count field |
| cfg_div | input | 4 | Sample divider field |
| ack_rdy | input | 1 | Acknowledge and clear the ready flag |
| ack_ovf | input | 1 | Clear the overflow flag |
| irq_mask | input | 2 | Mask: bit 0 ready, bit 1 overflow |
| ovf_event | input | 1 | External shutdown-overflow event |
| pool_data | input | 64 | Current accumulator value |
| sample_stb | output | 1 | Sample strobe |
| rnd_lo | output | 32 | Result bits 31:0 |
| rnd_hi | output | 32 | Result bits 63:32 |
| rdy_flag | output | 1 | Result available |
| ovf_flag | output | 1 | Shutdown-overflow flag |
| irq_masked | output | 2 | Flags ANDed with mask |
| irq | output | 1 | OR of the raw flags |
| busy | output | 1 | Running or in test mode |

## Verification
Random startup, divider and refill settings measure the clock distance from enable to the first flag, and from an acknowledge to the next flag. A startup or divider scaling error shows up separately from a refill error, and a zero minimum field (maximum governs) is told apart from a nonzero one (minimum governs). Each result is matched against a fresh accumulator value, which separates the direct output load from the spare-slot handoff. Directed cases cover the following:
- an inverted minimum/maximum pair;
- configuration writes made while enabled;
- strobe spacing;
- disabling in the middle of operation;
- set/clear collisions on the overflow flag.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_START  = 2'd1,
    PH_REFILL = 2'd2
  } phase_t;
endpackage

// File: rtl/seq_clkdiv.sv
module seq_clkdiv #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             stb
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run)       cnt_q <= '0;
    else if (cnt_q == div) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  assign stb = run && (cnt_q == div);

  // R2: with a divider above zero two strobes never touch
  a_r2_stb_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && div != '0) |=> !stb);
endmodule

// File: rtl/seq_phase_ctr.sv
module seq_phase_ctr
  import seq_pkg::*;
#(
  parameter int LONG_W   = 16,
  parameter int LONG_SH  = 8,
  parameter int SHORT_W  = 8,
  parameter int SHORT_SH = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               stb,
  input  logic [LONG_W-1:0]  startup_f,
  input  logic [LONG_W-1:0]  max_f,
  input  logic [SHORT_W-1:0] min_f,
  input  logic               out_free,
  input  logic               slot_free,
  output logic               running,
  output logic               release_o
);
  localparam int CNT_W = LONG_W + LONG_SH + 1;
  localparam logic [CNT_W-1:0] FULL = {1'b1, {(CNT_W-1){1'b0}}};

  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] st_tgt, max_tgt, min_tgt;
  logic             min_on, refill_ok, rel;

  always_comb begin
    st_tgt  = (startup_f == '0) ? FULL : (CNT_W'(startup_f) << LONG_SH);
    max_tgt = (max_f == '0)     ? FULL : (CNT_W'(max_f) << LONG_SH);
    min_tgt = CNT_W'(min_f) << SHORT_SH;
    min_on  = (min_f != '0);
    refill_ok = !(min_on && (min_tgt > max_tgt));
    cnt_n   = (cnt_q == FULL) ? cnt_q : cnt_q + 1'b1;
    rel = 1'b0;
    if (enable && stb) begin
      unique case (phase_q)
        PH_START:  rel = (cnt_n >= st_tgt) && slot_free;
        PH_REFILL: rel = refill_ok &&
                         ((min_on && cnt_n >= min_tgt && out_free) ||
                          (cnt_n >= max_tgt && slot_free));
        default:   rel = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (!enable) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (phase_q == PH_IDLE) begin
      phase_q <= PH_START;
      cnt_q   <= '0;
    end else if (rel) begin
      phase_q <= PH_REFILL;
      cnt_q   <= '0;
    end else if (stb) begin
      cnt_q   <= cnt_n;
    end
  end

  assign running   = (phase_q != PH_IDLE);
  assign release_o = rel;

  // R8: a low enable leaves the sequencer idle after the edge
  a_r8_idle_after_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/seq_result_buf.sv
module seq_result_buf #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              release_i,
  input  logic              ack,
  input  logic [2*WORD_W-1:0] pool,
  output logic [WORD_W-1:0] rnd_lo,
  output logic [WORD_W-1:0] rnd_hi,
  output logic              rdy,
  output logic              out_free,
  output logic              slot_free
);
  logic [2*WORD_W-1:0] out_q, spare_q;
  logic                rdy_q, spare_v_q, mv_q, ack_eff;

  assign ack_eff   = ack && rdy_q;
  assign out_free  = !(rdy_q || mv_q) || (ack_eff && !spare_v_q);
  assign slot_free = out_free || !spare_v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0; spare_q <= '0; rdy_q <= 1'b0; spare_v_q <= 1'b0; mv_q <= 1'b0;
    end else if (!enable) begin
      out_q <= '0; spare_q <= '0; rdy_q <= 1'b0; spare_v_q <= 1'b0; mv_q <= 1'b0;
    end else begin
      mv_q <= 1'b0;
      if (mv_q) begin
        out_q     <= spare_q;
        rdy_q     <= 1'b1;
        spare_v_q <= 1'b0;
      end else begin
        if (ack_eff) begin
          rdy_q <= 1'b0;
          mv_q  <= spare_v_q;
        end
        if (release_i) begin
          if (out_free) begin
            out_q <= pool;
            rdy_q <= 1'b1;
          end else begin
            spare_q   <= pool;
            spare_v_q <= 1'b1;
          end
        end
      end
    end
  end

  assign rnd_lo = out_q[WORD_W-1:0];
  assign rnd_hi = out_q[2*WORD_W-1:WORD_W];
  assign rdy    = rdy_q;

  // R7: unacknowledged output words are never overwritten
  a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_q && !ack && enable) |=> $stable(out_q));
  // R7: a waiting spare value stays put until it is moved
  a_r7_spare_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (spare_v_q && !mv_q && enable) |=> $stable(spare_q));
  // R6: the flag only rises from a release or a spare handoff
  a_r6_rdy_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> $past(release_i || mv_q));
endmodule

// File: rtl/seq_irq.sv
module seq_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rdy,
  input  logic       ovf_event,
  input  logic       ack_ovf,
  input  logic [1:0] mask,
  output logic       ovf_flag,
  output logic [1:0] masked,
  output logic       irq
);
  logic ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovf_q <= 1'b0;
    else if (ovf_event) ovf_q <= 1'b1;
    else if (ack_ovf)   ovf_q <= 1'b0;
  end

  assign ovf_flag = ovf_q;
  assign masked   = {ovf_q & mask[1], rdy & mask[0]};
  assign irq      = ovf_q | rdy;

  // R11: an event always leaves the flag set, even against a clear
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_event |=> ovf_q);
endmodule

// File: rtl/entropy_refill_seq.sv
module entropy_refill_seq #(
  parameter int WORD_W   = 32,
  parameter int LONG_W   = 16,
  parameter int LONG_SH  = 8,
  parameter int SHORT_W  = 8,
  parameter int SHORT_SH = 6,
  parameter int DIV_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                test_mode,
  input  logic                cfg_we,
  input  logic [LONG_W-1:0]   cfg_startup,
  input  logic [LONG_W-1:0]   cfg_refill_max,
  input  logic [SHORT_W-1:0]  cfg_refill_min,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic                ack_rdy,
  input  logic                ack_ovf,
  input  logic [1:0]          irq_mask,
  input  logic                ovf_event,
  input  logic [2*WORD_W-1:0] pool_data,
  output logic                sample_stb,
  output logic [WORD_W-1:0]   rnd_lo,
  output logic [WORD_W-1:0]   rnd_hi,
  output logic                rdy_flag,
  output logic                ovf_flag,
  output logic [1:0]          irq_masked,
  output logic                irq,
  output logic                busy
);
  logic [LONG_W-1:0]  startup_q, max_q;
  logic [SHORT_W-1:0] min_q;
  logic [DIV_W-1:0]   div_q;
  logic running, stb, rel, out_free, slot_free;

  // configuration is frozen while enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      startup_q <= '0; max_q <= '0; min_q <= '0; div_q <= '0;
    end else if (cfg_we && !enable) begin
      startup_q <= cfg_startup;
      max_q     <= cfg_refill_max;
      min_q     <= cfg_refill_min;
      div_q     <= cfg_div;
    end
  end

  seq_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(enable && running), .div(div_q), .stb(stb)
  );

  seq_phase_ctr #(
    .LONG_W(LONG_W), .LONG_SH(LONG_SH), .SHORT_W(SHORT_W), .SHORT_SH(SHORT_SH)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .enable(enable), .stb(stb),
    .startup_f(startup_q), .max_f(max_q), .min_f(min_q),
    .out_free(out_free), .slot_free(slot_free),
    .running(running), .release_o(rel)
  );

  seq_result_buf #(.WORD_W(WORD_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .enable(enable), .release_i(rel), .ack(ack_rdy),
    .pool(pool_data), .rnd_lo(rnd_lo), .rnd_hi(rnd_hi), .rdy(rdy_flag),
    .out_free(out_free), .slot_free(slot_free)
  );

  seq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .rdy(rdy_flag), .ovf_event(ovf_event),
    .ack_ovf(ack_ovf), .mask(irq_mask), .ovf_flag(ovf_flag),
    .masked(irq_masked), .irq(irq)
  );

  assign sample_stb = stb;
  assign busy       = running || test_mode;

  // R10: test mode always keeps busy asserted
  a_r10_busy_test: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> busy);
  // R9: frozen configuration does not move while enabled
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> $stable({startup_q, max_q, min_q, div_q}));
endmodule

// File: tb/entropy_refill_seq_bench.sv
module entropy_refill_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, test_mode = 1'b0, cfg_we = 1'b0;
  logic [15:0] cfg_startup = '0, cfg_refill_max = '0;
  logic [7:0]  cfg_refill_min = '0;
  logic [3:0]  cfg_div = '0;
  logic        ack_rdy = 1'b0, ack_ovf = 1'b0, ovf_event = 1'b0;
  logic [1:0]  irq_mask = '0;
  logic [63:0] pool_data = '0;
  logic        sample_stb, rdy_flag, ovf_flag, irq, busy;
  logic [31:0] rnd_lo, rnd_hi;
  logic [1:0]  irq_masked;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  entropy_refill_seq u_entropy_refill_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .test_mode(test_mode),
    .cfg_we(cfg_we), .cfg_startup(cfg_startup), .cfg_refill_max(cfg_refill_max),
    .cfg_refill_min(cfg_refill_min), .cfg_div(cfg_div), .ack_rdy(ack_rdy),
    .ack_ovf(ack_ovf), .irq_mask(irq_mask), .ovf_event(ovf_event),
    .pool_data(pool_data), .sample_stb(sample_stb), .rnd_lo(rnd_lo),
    .rnd_hi(rnd_hi), .rdy_flag(rdy_flag), .ovf_flag(ovf_flag),
    .irq_masked(irq_masked), .irq(irq), .busy(busy)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d exp<=190000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int long_cnt(input int f);
    return (f == 0) ? (1 << 24) : f * 256;
  endfunction

  function automatic int refill_cnt(input int mx, input int mn);
    return (mn == 0) ? long_cnt(mx) : mn * 64;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input int st, input int mx, input int mn, input int dv);
    cfg_startup = 16'(st); cfg_refill_max = 16'(mx);
    cfg_refill_min = 8'(mn); cfg_div = 4'(dv);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_rdy(input int limit, output int k);
    k = 0;
    do begin
      @(negedge clk);
      k = k + 1;
      if (k == 1) ack_rdy = 1'b0;
    end while (!rdy_flag && k < limit);
  endtask

  task automatic pulse_ack;
    ack_rdy = 1'b1;
    @(negedge clk);
    ack_rdy = 1'b0;
  endtask

  initial begin
    int k;
    logic [63:0] p1, p2, p3, p4;
    void'($urandom(32'd4242));

    // R12: reset state
    #1;
    check("R12 rdy", 64'(rdy_flag), 0);
    check("R12 words", {rnd_hi, rnd_lo}, 0);
    check("R12 irq/busy/stb", {60'd0, irq, busy, sample_stb, ovf_flag}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: busy from test mode and idle
    check("R10 idle busy", 64'(busy), 0);
    test_mode = 1'b1; @(negedge clk);
    check("R10 test busy", 64'(busy), 1);
    test_mode = 1'b0; @(negedge clk);
    check("R10 test off", 64'(busy), 0);
    check("R2 idle stb", 64'(sample_stb), 0);

    // R2: strobe spacing with divider 2
    write_cfg(4, 4, 0, 2);
    enable = 1'b1;
    begin
      int last = -1;
      int gap_bad = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (sample_stb) begin
          if (last >= 0 && (i - last) != 3) gap_bad = gap_bad + 1;
          last = i;
        end
      end
      check("R2 strobe period", 64'(gap_bad), 0);
      check("R10 running busy", 64'(busy), 1);
    end
    // R8: disable mid-startup
    enable = 1'b0; #1;
    check("R8 stb drops same cycle", 64'(sample_stb), 0);
    @(negedge clk);
    check("R8 busy idle", 64'(busy), 0);

    // random configurations: startup, refill, spare handoff, disable
    for (int it = 0; it < 8; it++) begin
      int d, s, mx, mn, t2;
      d  = int'($urandom % 4);
      s  = 1 + int'($urandom % 3);
      mx = 1 + int'($urandom % 2);
      mn = ($urandom % 3 == 0) ? 0 : 1 + int'($urandom % (4 * mx));
      p1 = {$urandom, $urandom}; p2 = {$urandom, $urandom};
      p3 = {$urandom, $urandom}; p4 = {$urandom, $urandom};
      write_cfg(s, mx, mn, d);
      pool_data = p1;
      enable = 1'b1;
      wait_rdy(20000, k);
      check("R1 startup cycles", 64'(k), 64'((d + 1) * long_cnt(s) + 1));
      check("R6 first result", {rnd_hi, rnd_lo}, p1);
      // acknowledge at once; next result comes after the refill count
      pool_data = p2;
      ack_rdy = 1'b1;
      wait_rdy(20000, k);
      t2 = refill_cnt(mx, mn);
      if (mn == 0) check("R3 refill at max", 64'(k), 64'((d + 1) * t2));
      else         check("R4 refill at min", 64'(k), 64'((d + 1) * t2));
      check("R6 refill data", {rnd_hi, rnd_lo}, p2);
      // leave unread so the spare slot fills
      pool_data = p3;
      repeat ((d + 1) * long_cnt(mx) + 4) @(negedge clk);
      pool_data = p4;
      check("R7 output held", {rnd_hi, rnd_lo}, p2);
      check("R7 still ready", 64'(rdy_flag), 1);
      pulse_ack;
      check("R7 gap cycle", 64'(rdy_flag), 0);
      @(negedge clk);
      check("R7 handoff ready", 64'(rdy_flag), 1);
      check("R7 spare data", {rnd_hi, rnd_lo}, p3);
      enable = 1'b0; #1;
      check("R8 stb off", 64'(sample_stb), 0);
      @(negedge clk);
      check("R8 rdy cleared", 64'(rdy_flag), 0);
      // after re-enable only a fresh startup result appears, not the old spare
    end

    // R6: acknowledge with no result pending does nothing
    write_cfg(1, 1, 0, 0);
    pool_data = 64'h1111_2222_3333_4444;
    enable = 1'b1;
    wait_rdy(2000, k);
    check("R1 min startup", 64'(k), 257);
    pulse_ack;
    pulse_ack;
    check("R6 idle ack", {63'd0, rdy_flag}, 0);
    check("R6 idle ack words", {rnd_hi, rnd_lo}, 64'h1111_2222_3333_4444);
    enable = 1'b0; @(negedge clk);

    // R9: writes while enabled are ignored
    enable = 1'b1;
    write_cfg(3, 2, 0, 3);
    enable = 1'b0; @(negedge clk);
    enable = 1'b1;
    wait_rdy(20000, k);
    check("R9 locked cfg", 64'(k), 257);
    enable = 1'b0; @(negedge clk);

    // R5: minimum above maximum stops refill results
    write_cfg(1, 1, 5, 0);
    enable = 1'b1;
    wait_rdy(2000, k);
    check("R5 startup still works", 64'(rdy_flag), 1);
    ack_rdy = 1'b1;
    wait_rdy(1500, k);
    check("R5 no refill", 64'(rdy_flag), 0);
    enable = 1'b0; @(negedge clk);

    // R11: overflow flag, mask and interrupt
    irq_mask = 2'b10;
    ovf_event = 1'b1; @(negedge clk); ovf_event = 1'b0;
    check("R11 set", 64'(ovf_flag), 1);
    check("R11 irq", 64'(irq), 1);
    check("R11 masked", 64'(irq_masked), 2);
    irq_mask = 2'b01; #1;
    check("R11 masked off", 64'(irq_masked), 0);
    ovf_event = 1'b1; ack_ovf = 1'b1; @(negedge clk);
    ovf_event = 1'b0;
    check("R11 set wins", 64'(ovf_flag), 1);
    @(negedge clk); ack_ovf = 1'b0;
    check("R11 cleared", 64'(ovf_flag), 0);
    check("R11 irq low", 64'(irq), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule